// File: doc/BRIEF.md
# Filtered Two-Level Trace Tag Store

This block keeps the tags of built instruction traces, each with a small usage counter. It does not keep the instructions themselves. There are two set-associative arrays of equal geometry. The first is a filter array, which receives every freshly built trace. The second is a main array, which holds only traces that have shown they are reused. A lookup port searches both arrays at once, reports whether and where the tag was found, and bumps that entry's counter. The counter saturates rather than wrapping.

When a new tag lands in a full filter set, the least recently used entry of that set is pushed out together with its counter. In the following cycle a static threshold filter looks at the count. The entry moves into the main array if its count reaches the selected threshold, and is dropped otherwise. An entry pushed out of the main array is simply lost. A tag therefore never sits in both arrays at once.

The set index is an XOR fold of the whole tag. The tag holds the start address together with the branch descriptors. While a promotion is pending, any lookup or insert that maps to the same set is held off for that one cycle.

Top module: `trace_tag_filter`

## Requirements
- R1: After reset both arrays are empty: every lookup misses, `vic_valid` is 0, and both ready outputs are 1 when no other input is active.
- R2: The set index bit i is the XOR of every tag bit whose position modulo IDX_W equals i. Tags with the same index compete for the same 8 ways.
- R3: An accepted insert writes the tag into the filter array with count 0. An insert whose tag is already in either array changes nothing, so the existing count is kept.
- R4: An accepted lookup gives its result in the next cycle. `res_valid`=1, and `res_hit` tells whether the tag was found. `res_main`=1 means it was found in the main array and 0 means the filter array. `res_cnt` is the count after the increment. A miss gives `res_hit`=0, `res_main`=0 and `res_cnt`=0.
- R5: A counter stops at 2^CNT_W-1 (7 by default) and never wraps.
- R6: Each set uses LRU replacement among 8 ways, and empty ways are filled before any entry is evicted. A lookup hit and an insert both make the entry most recently used.
- R7: In the cycle after an insert evicts a filter entry, `vic_valid`=1 and `vic_tag` and `vic_cnt` show the evicted entry. `vic_promote`=1 exactly when `vic_cnt` >= `thr_sel`+1.
- R8: A promoted tag is then found only in the main array, and its count continues from the carried value. A discarded tag misses.
- R9: A promotion into a full main set evicts that set's LRU entry, which is dropped and misses afterwards.
- R10: `lkp_ready`=0 while `ins_valid`=1. `lkp_ready` and `ins_ready` are both 0 for a tag whose set equals the set of an entry shown on `vic_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_sel | input | 2 | Promotion threshold minus one |
| ins_valid | input | 1 | Insert request for a newly built trace |
| ins_tag | input | TAG_W | Tag to insert |
| ins_ready | output | 1 | Insert accepted this cycle |
| lkp_valid | input | 1 | Lookup request |
| lkp_tag | input | TAG_W | Tag to look up |
| lkp_ready | output | 1 | Lookup accepted this cycle |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Tag found |
| res_main | output | 1 | Found in the main array |
| res_cnt | output | CNT_W | Count after this access |
| vic_valid | output | 1 | Filter victim under decision |
| vic_promote | output | 1 | Victim moves to the main array |
| vic_tag | output | TAG_W | Victim tag |
| vic_cnt | output | CNT_W | Victim access count |

## Verification
Some properties are checked by assertions on every cycle. No set ever matches one tag in two ways, and no probe hits both arrays at once. Lookup results and victim reports appear only one cycle after an accepted request, and a hit never reports a count of zero. The bench scenarios are needed for the rest. They show the LRU order in which victims leave, the threshold boundary between promotion and discard, the count carried into the main array, the saturation value, the loss of main-array victims and the same-set stall during a pending promotion.

// File: rtl/tts_pkg.sv
package tts_pkg;
    // Operation classes used by the stores
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TOUCH = 2'd1,
        ST_FILL  = 2'd2
    } st_op_e;
endpackage

// File: rtl/tts_hash.sv
module tts_hash #(
    parameter int TAG_W = 12,
    parameter int IDX_W = 2
) (
    input  logic [TAG_W-1:0] tag,
    output logic [IDX_W-1:0] idx
);
    // R2: fold all tag bits onto the index width
    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        logic b;
        always_comb begin
            b = 1'b0;
            for (int j = i; j < TAG_W; j += IDX_W) b = b ^ tag[j];
        end
        assign idx[i] = b;
    end
endmodule

// File: rtl/tts_store.sv
module tts_store #(
    parameter int TAG_W = 12,
    parameter int IDX_W = 2,
    parameter int WAYS  = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] p_idx,
    input  logic [TAG_W-1:0] p_tag,
    output logic             p_hit,
    output logic [CNT_W-1:0] p_cnt,
    input  logic             touch_en,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] f_idx,
    input  logic [TAG_W-1:0] f_tag,
    input  logic [CNT_W-1:0] f_cnt,
    output logic             v_full,
    output logic [TAG_W-1:0] v_tag,
    output logic [CNT_W-1:0] v_cnt
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WAY_W = $clog2(WAYS);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);
    localparam logic [CNT_W-1:0] CMAX   = {CNT_W{1'b1}};

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
        logic [WAY_W-1:0] age;
    } ent_t;

    ent_t ent_q [SETS][WAYS];
    ent_t ent_d [SETS][WAYS];

    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] fill_way;
    logic             has_free;
    logic [WAY_W-1:0] hit_age;

    // Probe
    always_comb begin
        hit_vec = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = ent_q[p_idx][w].vld && (ent_q[p_idx][w].tag == p_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        p_hit   = |hit_vec;
        p_cnt   = ent_q[p_idx][hit_way].cnt;
        hit_age = ent_q[p_idx][hit_way].age;
    end

    // Replacement choice: first empty way, else the oldest (R6)
    always_comb begin
        has_free = 1'b0;
        fill_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!has_free && !ent_q[f_idx][w].vld) begin
                has_free = 1'b1;
                fill_way = WAY_W'(w);
            end
        end
        if (!has_free) begin
            for (int w = 0; w < WAYS; w++)
                if (ent_q[f_idx][w].age == OLDEST) fill_way = WAY_W'(w);
        end
        v_full = !has_free;
        v_tag  = ent_q[f_idx][fill_way].tag;
        v_cnt  = ent_q[f_idx][fill_way].cnt;
    end

    // Next state
    always_comb begin
        ent_d = ent_q;
        if (touch_en) begin
            for (int w = 0; w < WAYS; w++)
                if (ent_q[p_idx][w].vld && ent_q[p_idx][w].age < hit_age)
                    ent_d[p_idx][w].age = ent_q[p_idx][w].age + 1'b1;
            ent_d[p_idx][hit_way].age = '0;
            if (ent_q[p_idx][hit_way].cnt != CMAX)
                ent_d[p_idx][hit_way].cnt = ent_q[p_idx][hit_way].cnt + 1'b1;
        end
        if (fill_en) begin
            for (int w = 0; w < WAYS; w++)
                if (ent_q[f_idx][w].vld && ent_q[f_idx][w].age < OLDEST)
                    ent_d[f_idx][w].age = ent_q[f_idx][w].age + 1'b1;
            ent_d[f_idx][fill_way] = '{vld: 1'b1, tag: f_tag, cnt: f_cnt, age: '0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    ent_q[s][w] <= '{vld: 1'b0, tag: '0, cnt: '0, age: OLDEST};
        end else begin
            ent_q <= ent_d;
        end
    end

    AST_ONE_WAY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R3
endmodule

// File: rtl/trace_tag_filter.sv
module trace_tag_filter #(
    parameter int TAG_W = 12,
    parameter int IDX_W = 2,
    parameter int WAYS  = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       thr_sel,
    input  logic             ins_valid,
    input  logic [TAG_W-1:0] ins_tag,
    output logic             ins_ready,
    input  logic             lkp_valid,
    input  logic [TAG_W-1:0] lkp_tag,
    output logic             lkp_ready,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_main,
    output logic [CNT_W-1:0] res_cnt,
    output logic             vic_valid,
    output logic             vic_promote,
    output logic [TAG_W-1:0] vic_tag,
    output logic [CNT_W-1:0] vic_cnt
);
    import tts_pkg::*;

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             pv;
        logic [TAG_W-1:0] ptag;
        logic [CNT_W-1:0] pcnt;
        logic             rv;
        logic             rhit;
        logic             rmain;
        logic [CNT_W-1:0] rcnt;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0] idx_l, idx_i, idx_p, probe_idx;
    logic [TAG_W-1:0] probe_tag;
    logic             f_hit, m_hit;
    logic [CNT_W-1:0] f_cnt, m_cnt, hit_cnt, thr;
    logic             f_vfull;
    logic [TAG_W-1:0] f_vtag;
    logic [CNT_W-1:0] f_vcnt;
    logic             unused_m_vfull;
    logic [TAG_W-1:0] unused_m_vtag;
    logic [CNT_W-1:0] unused_m_vcnt;
    logic             ins_go, lkp_go, f_fill, f_touch, m_touch, promote;
    st_op_e           op_now;

    tts_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash_l (.tag(lkp_tag),   .idx(idx_l));
    tts_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash_i (.tag(ins_tag),   .idx(idx_i));
    tts_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash_p (.tag(st_q.ptag), .idx(idx_p));

    // Handshake and control
    always_comb begin
        thr       = CNT_W'(thr_sel) + 1'b1;
        ins_ready = !(st_q.pv && (idx_i == idx_p));
        lkp_ready = !ins_valid && !(st_q.pv && (idx_l == idx_p));
        ins_go    = ins_valid && ins_ready;
        lkp_go    = lkp_valid && lkp_ready;
        probe_tag = ins_valid ? ins_tag : lkp_tag;
        probe_idx = ins_valid ? idx_i   : idx_l;
        f_fill    = ins_go && !f_hit && !m_hit;
        f_touch   = lkp_go && f_hit;
        m_touch   = lkp_go && m_hit;
        promote   = st_q.pv && (st_q.pcnt >= thr);
        op_now    = f_fill ? ST_FILL : ((f_touch || m_touch) ? ST_TOUCH : ST_IDLE);
        hit_cnt   = m_hit ? m_cnt : f_cnt;
    end

    tts_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS), .CNT_W(CNT_W)) u_filter (
        .clk(clk), .rst_n(rst_n),
        .p_idx(probe_idx), .p_tag(probe_tag), .p_hit(f_hit), .p_cnt(f_cnt),
        .touch_en(f_touch), .fill_en(f_fill),
        .f_idx(idx_i), .f_tag(ins_tag), .f_cnt('0),
        .v_full(f_vfull), .v_tag(f_vtag), .v_cnt(f_vcnt)
    );

    tts_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS), .CNT_W(CNT_W)) u_main (
        .clk(clk), .rst_n(rst_n),
        .p_idx(probe_idx), .p_tag(probe_tag), .p_hit(m_hit), .p_cnt(m_cnt),
        .touch_en(m_touch), .fill_en(promote),
        .f_idx(idx_p), .f_tag(st_q.ptag), .f_cnt(st_q.pcnt),
        .v_full(unused_m_vfull), .v_tag(unused_m_vtag), .v_cnt(unused_m_vcnt)
    );

    // Next state
    always_comb begin
        st_d      = st_q;
        st_d.pv   = (op_now == ST_FILL) && f_vfull;
        st_d.ptag = f_vtag;
        st_d.pcnt = f_vcnt;
        st_d.rv   = lkp_go;
        st_d.rhit = lkp_go && (f_hit || m_hit);
        st_d.rmain = lkp_go && m_hit;
        st_d.rcnt = '0;
        if (lkp_go && (f_hit || m_hit))
            st_d.rcnt = (hit_cnt == CMAX) ? CMAX : hit_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid   = st_q.rv;
    assign res_hit     = st_q.rhit;
    assign res_main    = st_q.rmain;
    assign res_cnt     = st_q.rcnt;
    assign vic_valid   = st_q.pv;
    assign vic_promote = promote;
    assign vic_tag     = st_q.ptag;
    assign vic_cnt     = st_q.pcnt;

    AST_ARRAYS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        !(f_hit && m_hit)); // R8
    AST_HIT_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (res_cnt != '0)); // R5
    AST_RESULT_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lkp_valid && lkp_ready)); // R4
    AST_VICTIM_FOLLOWS_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> $past(ins_valid && ins_ready)); // R7
endmodule

// File: tb/tb_trace_tag_filter.sv
module tb_trace_tag_filter;
    localparam int TW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    thr_sel = 2'd1;
    logic          ins_valid = 1'b0;
    logic [TW-1:0] ins_tag = '0;
    logic          ins_ready;
    logic          lkp_valid = 1'b0;
    logic [TW-1:0] lkp_tag = '0;
    logic          lkp_ready;
    logic          res_valid, res_hit, res_main;
    logic [2:0]    res_cnt;
    logic          vic_valid, vic_promote;
    logic [TW-1:0] vic_tag;
    logic [2:0]    vic_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trace_tag_filter dut (
        .clk(clk), .rst_n(rst_n), .thr_sel(thr_sel),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_ready(ins_ready),
        .lkp_valid(lkp_valid), .lkp_tag(lkp_tag), .lkp_ready(lkp_ready),
        .res_valid(res_valid), .res_hit(res_hit), .res_main(res_main), .res_cnt(res_cnt),
        .vic_valid(vic_valid), .vic_promote(vic_promote), .vic_tag(vic_tag), .vic_cnt(vic_cnt)
    );

    function automatic logic [1:0] fold(input logic [TW-1:0] t);
        logic [1:0] r = '0;
        for (int j = 0; j < TW; j++) r[j % 2] = r[j % 2] ^ t[j];
        return r;
    endfunction

    // R2: tag with a chosen set index
    function automatic logic [TW-1:0] mk(input int s, input int k);
        logic [TW-1:0] t = TW'(k) << 2;
        t[1:0] = 2'(s) ^ fold(t);
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    logic       g_v, g_p;
    logic [TW-1:0] g_t;
    logic [2:0] g_c;
    logic       l_hit, l_main;
    logic [2:0] l_cnt;

    task automatic do_insert(input logic [TW-1:0] t);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_tag   = t;
        @(posedge clk);
        #1;
        ins_valid = 1'b0;
        g_v = vic_valid; g_p = vic_promote; g_t = vic_tag; g_c = vic_cnt;
        @(posedge clk);
        #1;
    endtask

    task automatic do_lookup(input logic [TW-1:0] t);
        @(negedge clk);
        chk(lkp_ready == 1'b1, "R10 ready idle", int'(lkp_ready), 1);
        lkp_valid = 1'b1;
        lkp_tag   = t;
        @(posedge clk);
        #1;
        lkp_valid = 1'b0;
        chk(res_valid == 1'b1, "R4 res_valid", int'(res_valid), 1);
        l_hit = res_hit; l_main = res_main; l_cnt = res_cnt;
    endtask

    task automatic t_reset();
        chk(vic_valid == 1'b0, "R1 vic_valid", int'(vic_valid), 0);
        chk(ins_ready == 1'b1, "R1 ins_ready", int'(ins_ready), 1);
        do_lookup(mk(2, 50));
        chk(l_hit == 1'b0, "R1 miss", int'(l_hit), 0);
        chk(l_cnt == 3'd0, "R4 miss count", int'(l_cnt), 0);
    endtask

    task automatic t_insert_lookup();
        do_insert(mk(0, 1));
        chk(g_v == 1'b0, "R3 no victim", int'(g_v), 0);
        do_lookup(mk(0, 1));
        chk(l_hit && !l_main, "R4 filter hit", int'({l_hit, l_main}), 2);
        chk(l_cnt == 3'd1, "R4 count 1", int'(l_cnt), 1);
        do_lookup(mk(0, 1));
        chk(l_cnt == 3'd2, "R4 count 2", int'(l_cnt), 2);
        do_insert(mk(0, 1));
        do_lookup(mk(0, 1));
        chk(l_cnt == 3'd3, "R3 duplicate ignored", int'(l_cnt), 3);
    endtask

    task automatic t_lru_promote();
        for (int k = 2; k <= 8; k++) begin
            do_insert(mk(0, k));
            chk(g_v == 1'b0, "R6 empty way used", int'(g_v), 0);
        end
        // ninth tag in set 0: evicts the LRU entry, probe stalls during pending
        @(negedge clk);
        ins_valid = 1'b1;
        ins_tag   = mk(0, 9);
        @(posedge clk);
        #1;
        ins_valid = 1'b0;
        g_v = vic_valid; g_p = vic_promote; g_t = vic_tag; g_c = vic_cnt;
        lkp_tag = mk(0, 2);
        #1;
        chk(lkp_ready == 1'b0, "R10 same-set lookup stalled", int'(lkp_ready), 0);
        lkp_tag = mk(1, 1);
        #1;
        chk(lkp_ready == 1'b1, "R10 other-set lookup free", int'(lkp_ready), 1);
        ins_tag = mk(0, 20);
        #1;
        chk(ins_ready == 1'b0, "R10 same-set insert stalled", int'(ins_ready), 0);
        @(posedge clk);
        #1;
        chk(g_v == 1'b1, "R7 victim valid", int'(g_v), 1);
        chk(g_t == mk(0, 1), "R6 LRU victim", int'(g_t), int'(mk(0, 1)));
        chk(g_c == 3'd3, "R7 victim count", int'(g_c), 3);
        chk(g_p == 1'b1, "R7 promote", int'(g_p), 1);
        do_lookup(mk(0, 1));
        chk(l_hit && l_main, "R8 in main", int'({l_hit, l_main}), 3);
        chk(l_cnt == 3'd4, "R8 count carried", int'(l_cnt), 4);
        do_insert(mk(0, 10));
        chk(g_v && g_t == mk(0, 2) && !g_p, "R7 discard cnt0", int'(g_p), 0);
        do_lookup(mk(0, 2));
        chk(l_hit == 1'b0, "R8 discarded misses", int'(l_hit), 0);
    endtask

    task automatic t_threshold_sat();
        thr_sel = 2'd3;
        do_insert(mk(1, 1));
        for (int i = 0; i < 4; i++) do_lookup(mk(1, 1));
        do_insert(mk(1, 2));
        for (int i = 0; i < 3; i++) do_lookup(mk(1, 2));
        for (int k = 3; k <= 8; k++) do_insert(mk(1, k));
        do_insert(mk(1, 9));
        chk(g_v && g_t == mk(1, 1), "R6 victim order", int'(g_t), int'(mk(1, 1)));
        chk(g_p == 1'b1, "R7 count 4 at threshold 4", int'(g_p), 1);
        do_insert(mk(1, 10));
        chk(g_v && g_t == mk(1, 2), "R6 victim order 2", int'(g_t), int'(mk(1, 2)));
        chk(g_p == 1'b0, "R7 count 3 below threshold 4", int'(g_p), 0);
        do_lookup(mk(1, 2));
        chk(l_hit == 1'b0, "R8 below threshold dropped", int'(l_hit), 0);
        for (int i = 0; i < 5; i++) do_lookup(mk(1, 1));
        chk(l_cnt == 3'd7, "R5 saturates", int'(l_cnt), 7);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        ins_valid = 1'b1; ins_tag = mk(2, 1);
        lkp_valid = 1'b1; lkp_tag = mk(1, 1);
        #1;
        chk(lkp_ready == 1'b0, "R10 lookup yields to insert", int'(lkp_ready), 0);
        chk(ins_ready == 1'b1, "R10 insert accepted", int'(ins_ready), 1);
        @(posedge clk);
        #1;
        ins_valid = 1'b0; lkp_valid = 1'b0;
        chk(res_valid == 1'b0, "R10 no result when stalled", int'(res_valid), 0);
        @(posedge clk);
        #1;
    endtask

    task automatic t_main_evict();
        thr_sel = 2'd0;
        for (int k = 1; k <= 8; k++) begin
            do_insert(mk(3, k));
            do_lookup(mk(3, k));
        end
        for (int k = 9; k <= 17; k++) begin
            do_insert(mk(3, k));
            chk(g_v && g_p, "R7 threshold 1 promotes", int'(g_p), 1);
            do_lookup(mk(3, k));
        end
        do_lookup(mk(3, 1));
        chk(l_hit == 1'b0, "R9 main victim dropped", int'(l_hit), 0);
        do_lookup(mk(3, 2));
        chk(l_hit && l_main, "R9 others kept", int'({l_hit, l_main}), 3);
        do_lookup(mk(3, 9));
        chk(l_hit && l_main, "R2 same set reaches main", int'({l_hit, l_main}), 3);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_insert_lookup();
        t_lru_promote();
        t_threshold_sat();
        t_same_cycle();
        t_main_evict();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule